// File: doc/BRIEF.md
# I2C Register Access Sequencer

This block turns one request word into one complete I2C master transaction that writes or reads a single 8-bit register in an I2C slave. The request arrives as a 25-bit word with a one-cycle valid strobe. The word names the slave address, the direction, the register index and, for writes, the data byte. The block drives the two bus lines as open-drain pull-downs and observes the resolved line levels. When the transaction is complete it presents a 25-bit result word together with a one-cycle strobe. The side that issued the request loads the result on that strobe.

A write goes out as START, address with write bit, register index, data byte, STOP. A read goes out as START, address with write bit, register index, repeated START, address with read bit, one received byte answered with NACK, STOP. The bit timing is taken from a divider on the system clock, in four quarter-periods per bit. A slave that holds the clock line low stretches the timing. A missing acknowledge does not stop the sequence: every phase still runs and STOP is always sent. The failure is reported in the result, and the block never retries on its own.

Top module: `i2c_reg_sequencer`

## Requirements
- R1: A request with `req_valid` high and enable bit 24 set, presented while `busy` is low, is taken; `busy` is high at the next clock.
- R2: A request whose enable bit 24 is 0 is ignored: no START or other activity on the bus, no result strobe, `busy` stays low and `rslt_word` keeps its value.
- R3: Request layout: bit 24 enable, bits 23:17 slave address, bit 16 direction (1 = read), bits 15:8 register index, bits 7:0 write data. A write request sends START, address+0, index, data, STOP, so the slave's register at that index receives the data (one START and one STOP).
- R4: A read request sends START, address+0, index, repeated START, address+1, reads one byte and answers it with NACK, then STOP (two STARTs, one STOP).
- R5: Result layout: bit 24 acknowledge error, bits 23:17 address, bit 16 direction, bits 15:8 index, bits 7:0 data. The data field holds the byte read for a read and the byte sent for a write.
- R6: The acknowledge-error bit is 1 when any acknowledge from the slave was missing (a missing byte reads as 8'hFF). The transaction still completes with STOP, and it is not retried.
- R7: `rslt_valid` is high for exactly one cycle, in the same cycle `busy` falls. `rslt_word` holds its value until the next result.
- R8: Requests that arrive while `busy` is high are ignored.
- R9: While a slave holds the clock line low after the block has released it, the block waits, and the transaction completes with the correct result.
- R10: `scl_pull`/`sda_pull` high means the line is pulled low, and low means the line is released. Both are low whenever `busy` is low.
- R11: Driving `rst_n` low at any time immediately clears `busy`, releases both lines and clears `rslt_word`. The next request then runs normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_word | input | 25 | Request: enable, address, direction, index, write data |
| req_valid | input | 1 | One-cycle strobe qualifying `req_word` |
| rslt_word | output | 25 | Result: ack error, address, direction, index, data |
| rslt_valid | output | 1 | One-cycle strobe when a new result is loaded |
| busy | output | 1 | High from acceptance until the result strobe |
| scl_in | input | 1 | Resolved level of the clock line |
| sda_in | input | 1 | Resolved level of the data line |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A behavioural slave on the resolved lines counts START and STOP conditions and keeps a register file. This exposes the write path, where register contents change, and the read path, where a repeated START happens and the returned byte matches. An unmatched address separates acknowledge-error reporting from normal completion: its read returns 8'hFF, and a long quiet window afterwards shows that no retry occurs. Disabled requests and requests issued while busy show that the request is gated. A slave that stretches the clock lengthens the transaction without corrupting it. A mid-transaction reset followed by a fresh write shows both the abort and the recovery.

// File: rtl/i2cra_pkg.sv
package i2cra_pkg;
   localparam int ADDR_W = 7;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 1 + ADDR_W + 1 + 2 * BYTE_W;

   typedef enum logic [1:0] {
      PHY_START = 2'd0,
      PHY_STOP  = 2'd1,
      PHY_WRITE = 2'd2,
      PHY_READ  = 2'd3
   } phy_op_t;

   typedef enum logic [2:0] {
      ST_IDLE, ST_START, ST_SEND, ST_ACKIN, ST_RESTART, ST_RECV, ST_NACKOUT, ST_STOP
   } seq_state_t;
endpackage

// File: rtl/i2cra_qtimer.sv
module i2cra_qtimer #(
   parameter int QUARTER_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic hold,
   output logic tick
);
   localparam int CNT_W = (QUARTER_CYC > 1) ? $clog2(QUARTER_CYC) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(QUARTER_CYC - 1);

   generate
      if (QUARTER_CYC < 1) begin : g_bad_quarter
         $error("QUARTER_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (!hold)  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
   end

   assign tick = run && !hold && (cnt == LAST);
endmodule

// File: rtl/i2cra_bitphy.sv
module i2cra_bitphy
   import i2cra_pkg::*;
#(
   parameter int QUARTER_CYC = 125
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    go,
   input  phy_op_t op,
   input  logic    wbit,
   input  logic    scl_in,
   input  logic    sda_in,
   output logic    done,
   output logic    rbit,
   output logic    scl_pull,
   output logic    sda_pull
);
   logic       active;
   phy_op_t    op_q;
   logic       wbit_q;
   logic [1:0] qtr;
   logic       scl_q, sda_q, rbit_q;
   logic       hold, tick;

   // pull pattern {scl, sda} for a quarter; cur keeps the clock level where needed
   function automatic logic [1:0] pulls(phy_op_t o, logic b, logic [1:0] q, logic [1:0] cur);
      logic [1:0] r;
      unique case (o)
         PHY_START: case (q)
            2'd0:    r = {cur[1], 1'b0};
            2'd1:    r = 2'b00;
            2'd2:    r = 2'b01;
            default: r = 2'b11;
         endcase
         PHY_STOP: case (q)
            2'd0:    r = 2'b11;
            2'd1:    r = 2'b01;
            default: r = 2'b00;
         endcase
         PHY_WRITE: r = {(q == 2'd0) || (q == 2'd3), ~b};
         default:   r = {(q == 2'd0) || (q == 2'd3), 1'b0};
      endcase
      return r;
   endfunction

   assign hold = active && ((qtr == 2'd1) || (qtr == 2'd2)) && !scl_in;

   i2cra_qtimer #(.QUARTER_CYC(QUARTER_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(active), .hold(hold), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         op_q   <= PHY_START;
         wbit_q <= 1'b0;
         qtr    <= 2'd0;
         scl_q  <= 1'b0;
         sda_q  <= 1'b0;
         rbit_q <= 1'b0;
      end else if (!active) begin
         if (go) begin
            active         <= 1'b1;
            op_q           <= op;
            wbit_q         <= wbit;
            qtr            <= 2'd0;
            {scl_q, sda_q} <= pulls(op, wbit, 2'd0, {scl_q, sda_q});
         end
      end else if (tick) begin
         if (qtr == 2'd2) rbit_q <= sda_in;
         if (qtr == 2'd3) begin
            active <= 1'b0;
         end else begin
            qtr            <= qtr + 2'd1;
            {scl_q, sda_q} <= pulls(op_q, wbit_q, qtr + 2'd1, {scl_q, sda_q});
         end
      end
   end

   assign done     = active && tick && (qtr == 2'd3);
   assign rbit     = rbit_q;
   assign scl_pull = scl_q;
   assign sda_pull = sda_q;

   // R9: a held-low clock line freezes the high phase
   a_r9_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
      (active && qtr == 2'd1 && !scl_in) |=> (active && qtr == 2'd1));

   // R10: data bits only move the data line while the clock line is pulled
   a_r10_data_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (op_q == PHY_WRITE || op_q == PHY_READ) && !$stable(sda_pull)) |-> scl_pull);
endmodule

// File: rtl/i2cra_ctrl.sv
module i2cra_ctrl
   import i2cra_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] req_word,
   input  logic              req_valid,
   input  logic              phy_done,
   input  logic              phy_rbit,
   output logic              phy_go,
   output phy_op_t           phy_op,
   output logic              phy_wbit,
   output logic [WORD_W-1:0] rslt_word,
   output logic              rslt_valid,
   output logic              busy
);
   localparam int EN_POS = WORD_W - 1;

   seq_state_t        state;
   logic [ADDR_W-1:0] addr_q;
   logic              rd_q;
   logic [BYTE_W-1:0] idx_q, data_q, rx_sh, cur_byte;
   logic [1:0]        sel;
   logic [2:0]        bitn;
   logic              issued, ack_err, rslt_v;
   logic [WORD_W-1:0] rslt_q;

   always_comb begin
      unique case (sel)
         2'd0:    cur_byte = {addr_q, 1'b0};
         2'd1:    cur_byte = idx_q;
         2'd2:    cur_byte = data_q;
         default: cur_byte = {addr_q, 1'b1};
      endcase
   end

   always_comb begin
      unique case (state)
         ST_SEND:             phy_op = PHY_WRITE;
         ST_NACKOUT:          phy_op = PHY_WRITE;
         ST_ACKIN, ST_RECV:   phy_op = PHY_READ;
         ST_STOP:             phy_op = PHY_STOP;
         default:             phy_op = PHY_START;
      endcase
   end

   assign phy_wbit = (state == ST_NACKOUT) ? 1'b1 : cur_byte[bitn];
   assign busy     = (state != ST_IDLE);
   assign phy_go   = busy && !issued;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         addr_q  <= '0;
         rd_q    <= 1'b0;
         idx_q   <= '0;
         data_q  <= '0;
         rx_sh   <= '0;
         sel     <= 2'd0;
         bitn    <= 3'd7;
         issued  <= 1'b0;
         ack_err <= 1'b0;
         rslt_v  <= 1'b0;
         rslt_q  <= '0;
      end else begin
         rslt_v <= 1'b0;
         if (state == ST_IDLE) begin
            if (req_valid && req_word[EN_POS]) begin
               addr_q  <= req_word[EN_POS-1 -: ADDR_W];
               rd_q    <= req_word[2*BYTE_W];
               idx_q   <= req_word[2*BYTE_W-1 -: BYTE_W];
               data_q  <= req_word[BYTE_W-1:0];
               ack_err <= 1'b0;
               issued  <= 1'b0;
               state   <= ST_START;
            end
         end else if (phy_done) begin
            issued <= 1'b0;
            unique case (state)
               ST_START: begin
                  sel <= 2'd0; bitn <= 3'd7; state <= ST_SEND;
               end
               ST_SEND: begin
                  if (bitn == 3'd0) state <= ST_ACKIN;
                  else bitn <= bitn - 3'd1;
               end
               ST_ACKIN: begin
                  if (phy_rbit) ack_err <= 1'b1;
                  bitn <= 3'd7;
                  unique case (sel)
                     2'd0: begin sel <= 2'd1; state <= ST_SEND; end
                     2'd1: begin
                        if (rd_q) begin sel <= 2'd3; state <= ST_RESTART; end
                        else begin sel <= 2'd2; state <= ST_SEND; end
                     end
                     2'd2:    state <= ST_STOP;
                     default: state <= ST_RECV;
                  endcase
               end
               ST_RESTART: begin bitn <= 3'd7; state <= ST_SEND; end
               ST_RECV: begin
                  rx_sh <= {rx_sh[BYTE_W-2:0], phy_rbit};
                  if (bitn == 3'd0) state <= ST_NACKOUT;
                  else bitn <= bitn - 3'd1;
               end
               ST_NACKOUT: state <= ST_STOP;
               default: begin
                  rslt_q <= {ack_err, addr_q, rd_q, idx_q, rd_q ? rx_sh : data_q};
                  rslt_v <= 1'b1;
                  state  <= ST_IDLE;
               end
            endcase
         end else if (phy_go) begin
            issued <= 1'b1;
         end
      end
   end

   assign rslt_word  = rslt_q;
   assign rslt_valid = rslt_v;

   // R2: a request with the enable bit clear leaves the sequencer idle
   a_r2_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && req_valid && !req_word[EN_POS]) |=> !busy);

   // R7: the result strobe marks the end of a busy period
   a_r7_strobe_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rslt_valid |-> (!busy && $past(busy)));

   // R6: no new transaction starts by itself after a result
   a_r6_no_self_retry: assert property (@(posedge clk) disable iff (!rst_n)
      (rslt_valid && !req_valid) |=> !busy);

   // R8: latched request fields do not change while a transaction runs
   a_r8_request_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(addr_q) && $stable(idx_q) && $stable(rd_q)));
endmodule

// File: rtl/i2c_reg_sequencer.sv
module i2c_reg_sequencer
   import i2cra_pkg::*;
#(
   parameter int QUARTER_CYC = 125,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] req_word,
   input  logic              req_valid,
   output logic [WORD_W-1:0] rslt_word,
   output logic              rslt_valid,
   output logic              busy,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              scl_pull,
   output logic              sda_pull
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 0..4");
      end
   endgenerate

   logic    scl_s, sda_s;
   logic    phy_go, phy_wbit, phy_done, phy_rbit;
   phy_op_t phy_op;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign scl_s = scl_in;
         assign sda_s = sda_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_ff <= '1;
               sda_ff <= '1;
            end else begin
               scl_ff[0] <= scl_in;
               sda_ff[0] <= sda_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  scl_ff[i] <= scl_ff[i-1];
                  sda_ff[i] <= sda_ff[i-1];
               end
            end
         end
         assign scl_s = scl_ff[SYNC_STAGES-1];
         assign sda_s = sda_ff[SYNC_STAGES-1];
      end
   endgenerate

   i2cra_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_word(req_word), .req_valid(req_valid),
      .phy_done(phy_done), .phy_rbit(phy_rbit),
      .phy_go(phy_go), .phy_op(phy_op), .phy_wbit(phy_wbit),
      .rslt_word(rslt_word), .rslt_valid(rslt_valid), .busy(busy)
   );

   i2cra_bitphy #(.QUARTER_CYC(QUARTER_CYC)) u_phy (
      .clk(clk), .rst_n(rst_n),
      .go(phy_go), .op(phy_op), .wbit(phy_wbit),
      .scl_in(scl_s), .sda_in(sda_s),
      .done(phy_done), .rbit(phy_rbit),
      .scl_pull(scl_pull), .sda_pull(sda_pull)
   );

   // R10: both lines are released whenever no transaction runs
   a_r10_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_pull && !sda_pull));
endmodule

// File: tb/tb_i2c_reg_sequencer.sv
module tb_i2c_reg_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int QC         = 4;
   localparam logic [6:0] SLV = 7'h2A;
   localparam int STRETCH_NS = 2000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [24:0] req_word = '0;
   logic        req_valid = 1'b0;
   logic [24:0] rslt_word;
   logic        rslt_valid, busy, scl_pull, sda_pull;
   logic        stretch = 1'b0, slv_pull = 1'b0, stretch_req = 1'b0;
   logic        scl_line, sda_line;

   assign scl_line = !(scl_pull || stretch);
   assign sda_line = !(sda_pull || slv_pull);

   i2c_reg_sequencer #(.QUARTER_CYC(QC), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .req_word(req_word), .req_valid(req_valid),
      .rslt_word(rslt_word), .rslt_valid(rslt_valid), .busy(busy),
      .scl_in(scl_line), .sda_in(sda_line), .scl_pull(scl_pull), .sda_pull(sda_pull)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, n_start = 0, n_stop = 0, n_rslt = 0, cyc = 0, base_cyc = 0;

   // behavioural slave
   logic [7:0] mem [256];
   logic [7:0] ptr = '0, rx_sh = '0, tx_sh = '0;
   int  bitc = 0, byte_no = 0;
   logic s_act = 0, tx = 0, rd = 0, m_ack = 0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

   always @(negedge sda_line) if (scl_line) begin
      n_start++; s_act = 1; bitc = 0; byte_no = 0; tx = 0; rd = 0; slv_pull = 0;
   end
   always @(posedge sda_line) if (scl_line) begin
      n_stop++; s_act = 0; slv_pull = 0;
   end
   always @(posedge scl_line) if (s_act) begin
      if (!tx && bitc < 8) rx_sh = {rx_sh[6:0], sda_line};
      if (tx && bitc == 8) m_ack = !sda_line;
      bitc++;
   end
   always @(negedge scl_line) if (s_act) begin
      if (!tx) begin
         if (bitc == 8) begin
            if (byte_no == 0) begin
               if (rx_sh[7:1] != SLV) s_act = 0; else rd = rx_sh[0];
            end else if (byte_no == 1 && !rd) ptr = rx_sh;
            else if (!rd) begin mem[ptr] = rx_sh; ptr++; end
            if (s_act) slv_pull = 1;
            if (s_act && stretch_req) begin
               stretch_req = 0; stretch = 1; #(STRETCH_NS); stretch = 0;
            end
         end else if (bitc == 9) begin
            slv_pull = 0; bitc = 0; byte_no++;
            if (rd) begin tx = 1; tx_sh = mem[ptr]; slv_pull = !tx_sh[7]; end
         end
      end else begin
         if (bitc >= 1 && bitc <= 7) slv_pull = !tx_sh[7-bitc];
         else if (bitc == 8) slv_pull = 0;
         else if (bitc == 9) begin
            bitc = 0; slv_pull = 0;
            if (!m_ack) s_act = 0;
            else begin ptr++; tx_sh = mem[ptr]; slv_pull = !tx_sh[7]; end
         end
      end
   end

   always @(negedge clk) if (rst_n && rslt_valid) n_rslt++;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic send(input logic [24:0] w);
      @(negedge clk); req_word = w; req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0;
   endtask

   task automatic wait_rslt(output int n);
      n = 0;
      while (n < 20000) begin
         @(negedge clk); #1; n++;
         if (rslt_valid) break;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic run_and_check(input logic [24:0] w, input logic [24:0] exp, input string req, output int n);
      send(w);
      wait_rslt(n);
      chk(rslt_valid === 1'b1, {req, " result strobe"}, 32'(rslt_valid), 1);
      chk(rslt_word === exp, {req, " result word"}, 32'(rslt_word), 32'(exp));
      @(negedge clk); #1;
      chk(rslt_valid === 1'b0 && busy === 1'b0, "R7 strobe one cycle", {30'b0, rslt_valid, busy}, 0);
      chk(rslt_word === exp, "R7 result held", 32'(rslt_word), 32'(exp));
   endtask

   task automatic t_reset_state;
      chk(busy === 1'b0 && rslt_valid === 1'b0, "R11 reset flags", {30'b0, busy, rslt_valid}, 0);
      chk(scl_pull === 1'b0 && sda_pull === 1'b0, "R10 reset lines released", {30'b0, scl_pull, sda_pull}, 0);
      chk(rslt_word === '0, "R11 reset result", 32'(rslt_word), 0);
   endtask

   task automatic t_write;
      int s0 = n_start, p0 = n_stop, n;
      send({1'b1, SLV, 1'b0, 8'h10, 8'hC3});
      #1; chk(busy === 1'b1, "R1 busy after accept", 32'(busy), 1);
      wait_rslt(n); base_cyc = n;
      chk(rslt_word === {1'b0, SLV, 1'b0, 8'h10, 8'hC3}, "R5 write result", 32'(rslt_word), 32'({1'b0, SLV, 1'b0, 8'h10, 8'hC3}));
      @(negedge clk); #1;
      chk(rslt_valid === 1'b0 && busy === 1'b0, "R7 strobe one cycle", {30'b0, rslt_valid, busy}, 0);
      chk(mem[8'h10] === 8'hC3, "R3 slave register written", 32'(mem[8'h10]), 32'hC3);
      chk(n_start - s0 == 1 && n_stop - p0 == 1, "R3 one START one STOP", 32'((n_start - s0) * 16 + (n_stop - p0)), 32'h11);
   endtask

   task automatic t_read;
      int s0 = n_start, n;
      run_and_check({1'b1, SLV, 1'b1, 8'h10, 8'h00}, {1'b0, SLV, 1'b1, 8'h10, 8'hC3}, "R4 read back", n);
      chk(n_start - s0 == 2, "R4 repeated START", 32'(n_start - s0), 2);
      run_and_check({1'b1, SLV, 1'b1, 8'h33, 8'hEE}, {1'b0, SLV, 1'b1, 8'h33, 8'h69}, "R4 read preset", n);
   endtask

   task automatic t_bad_addr;
      int s0 = n_start, p0 = n_stop, r0, n;
      run_and_check({1'b1, 7'h11, 1'b0, 8'h05, 8'h77}, {1'b1, 7'h11, 1'b0, 8'h05, 8'h77}, "R6 nack write", n);
      r0 = n_rslt;
      idle(3000);
      chk(n_rslt == r0 && n_start - s0 == 1 && busy === 1'b0, "R6 no retry", 32'(n_start - s0), 1);
      chk(n_stop - p0 == 1, "R6 STOP after nack", 32'(n_stop - p0), 1);
      chk(mem[8'h05] === 8'h5F, "R6 unaddressed slave untouched", 32'(mem[8'h05]), 32'h5F);
      run_and_check({1'b1, 7'h11, 1'b1, 8'h05, 8'h00}, {1'b1, 7'h11, 1'b1, 8'h05, 8'hFF}, "R6 nack read", n);
   endtask

   task automatic t_disabled;
      int s0 = n_start, r0 = n_rslt;
      logic [24:0] prev = rslt_word;
      send({1'b0, SLV, 1'b0, 8'h10, 8'h00});
      #1; chk(busy === 1'b0, "R2 not busy", 32'(busy), 0);
      idle(500);
      chk(n_start == s0 && n_rslt == r0, "R2 no bus activity or result", 32'(n_start - s0 + n_rslt - r0), 0);
      chk(scl_pull === 1'b0 && sda_pull === 1'b0, "R10 lines released when idle", {30'b0, scl_pull, sda_pull}, 0);
      chk(rslt_word === prev && mem[8'h10] === 8'hC3, "R2 state unchanged", 32'(rslt_word), 32'(prev));
   endtask

   task automatic t_busy_ignore;
      int r0 = n_rslt, n;
      send({1'b1, SLV, 1'b0, 8'h20, 8'hAA});
      idle(20);
      send({1'b1, SLV, 1'b0, 8'h20, 8'h55});
      wait_rslt(n);
      chk(rslt_word === {1'b0, SLV, 1'b0, 8'h20, 8'hAA}, "R8 first request wins", 32'(rslt_word), 32'({1'b0, SLV, 1'b0, 8'h20, 8'hAA}));
      idle(2500);
      chk(n_rslt - r0 == 1 && mem[8'h20] === 8'hAA, "R8 second request dropped", 32'(mem[8'h20]), 32'hAA);
   endtask

   task automatic t_stretch;
      int n;
      stretch_req = 1'b1;
      run_and_check({1'b1, SLV, 1'b0, 8'h40, 8'h3C}, {1'b0, SLV, 1'b0, 8'h40, 8'h3C}, "R9 stretched write", n);
      chk(n >= base_cyc + 150, "R9 waited for clock release", 32'(n), 32'(base_cyc + 150));
      chk(mem[8'h40] === 8'h3C, "R9 data intact", 32'(mem[8'h40]), 32'h3C);
   endtask

   task automatic t_reset_abort;
      int n;
      send({1'b1, SLV, 1'b0, 8'h50, 8'h99});
      idle(200);
      rst_n = 1'b0; #1;
      chk(busy === 1'b0 && scl_pull === 1'b0 && sda_pull === 1'b0, "R11 async abort", {29'b0, busy, scl_pull, sda_pull}, 0);
      chk(rslt_word === '0, "R11 result cleared", 32'(rslt_word), 0);
      s_act = 0; slv_pull = 0; tx = 0;
      idle(5); rst_n = 1'b1; idle(5);
      run_and_check({1'b1, SLV, 1'b0, 8'h51, 8'h81}, {1'b0, SLV, 1'b0, 8'h51, 8'h81}, "R11 recovery", n);
      chk(mem[8'h51] === 8'h81, "R11 recovery write", 32'(mem[8'h51]), 32'h81);
   endtask

   initial begin
      idle(5);
      t_reset_state();
      rst_n = 1'b1;
      idle(5);
      t_write();
      t_read();
      t_bad_addr();
      t_disabled();
      t_busy_ignore();
      t_stretch();
      t_reset_abort();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule